// File: doc/BRIEF.md
# Third-Order Noise-Shaped Divide Modulus Controller

This block turns a fixed fractional frequency word into a new divide modulus for a multi-modulus prescaler on every enabled tick of the divided feedback clock. It uses three first-order accumulators in cascade. Each accumulator has the width of the fractional word, 16 bits by default. The first stage adds the word. The second adds the updated sum of the first, and the third adds the updated sum of the second. The three overflow bits are combined with first and second differences into one signed value y. This value follows the fraction with its error shaped towards high frequencies. Because the structure is feed-forward only, it cannot go unstable.

The value y lies between -3 and +4. It is offered in two forms: a 3-bit code equal to y+3, and a modulus equal to 27+y, which spans 24 to 31 and averages 27 plus K/2^W. Both outputs are registered. They change only on clock edges where the enable is high. A synchronous active-high reset returns the block to its idle state.

Top module: `mash_modulus_ctrl`

## Requirements
- R1: While the synchronous reset is high at a rising edge, all three accumulators and the carry history are cleared, and the outputs become code 3 and modulus 27 at that edge.
- R2: On an enabled edge, stage one adds the word K. Stage two adds stage one's new sum, and stage three adds stage two's new sum, each modulo 2^W. The overflow bits a, b and c then form y = a + (b - b') + (c - 2c' + c''). Here a prime marks the value from the previous enabled edge. y is registered at that same edge. From reset with K = 2^(W-1), the first four outputs are codes 3, 5, 2, 4.
- R3: The code output equals y+3 and the modulus output equals 27+y. The modulus therefore always lies in 24..31 and always equals code + 24.
- R4: After n enabled edges from reset, the running sum of (modulus - 27) lies within -1..+2 of floor(n*K/2^W). Over 2^W enabled edges, the sum is therefore K-1..K+2 and the mean is K/2^W.
- R5: An edge with the enable low changes neither the accumulators, the carry history nor the outputs.
- R6: With K = 0 from reset, every output is code 3 (modulus 27), and the accumulators stay at zero.
- R7: With K = 2^W - 1 from reset, the first output is code 3 and the second output is code 6 (modulus 30).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided feedback clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; the modulator advances only on edges where it is high |
| frac_word | input | ACC_W | Fractional frequency word K, unsigned |
| code | output | 3 | Registered modulation code, y+3 |
| modulus | output | MOD_W | Registered prescaler divide value, 27+y |

## Verification
Some properties are checked by the assertions on every clock cycle. These are: the modulus stays inside its eight-value window, the modulus matches the code, outputs and accumulators are frozen on idle edges, a zero word keeps cleared accumulators cleared, and the reset values are right. The bench scenarios are needed for the arithmetic, which no single-cycle property can capture. They sweep the word across a reduced-width configuration and compare the running output sum with floor(n*K/2^W) after every edge. They also check exact early output sequences for the half-scale and full-scale words, and confirm that an idle gap in the middle of a run leaves the long-term average intact.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int unsigned MASH_STAGES = 3;
  localparam int unsigned CODE_W      = 3;
  localparam int          Y_MIN       = -3;
  localparam int          CODE_OFS    = -Y_MIN;
endpackage

// File: rtl/mash_accum.sv
module mash_accum #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum_q,
  output logic [W-1:0] sum_nx,
  output logic         carry
);
  logic [W:0] total;

  assign total  = {1'b0, sum_q} + {1'b0, addend};
  assign carry  = total[W];
  assign sum_nx = total[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
    end else if (en) begin
      sum_q <= sum_nx;
    end
  end
endmodule

// File: rtl/mash_combiner.sv
module mash_combiner
  import mash_pkg::*;
#(
  parameter int unsigned MOD_BASE = 27,
  parameter int unsigned MOD_W    = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [MASH_STAGES-1:0] carry,
  output logic [CODE_W-1:0]      code_q,
  output logic [MOD_W-1:0]       mod_q
);
  logic b_d, c_d, c_dd;
  int   y;

  always_comb begin
    y = int'(carry[0])
      + int'(carry[1]) - int'(b_d)
      + int'(carry[2]) - 2 * int'(c_d) + int'(c_dd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_d    <= 1'b0;
      c_d    <= 1'b0;
      c_dd   <= 1'b0;
      code_q <= CODE_W'(CODE_OFS);
      mod_q  <= MOD_W'(MOD_BASE);
    end else if (en) begin
      b_d    <= carry[1];
      c_d    <= carry[2];
      c_dd   <= c_d;
      code_q <= CODE_W'(y + CODE_OFS);
      mod_q  <= MOD_W'(int'(MOD_BASE) + y);
    end
  end
endmodule

// File: rtl/mash_modulus_ctrl.sv
module mash_modulus_ctrl
  import mash_pkg::*;
#(
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned MOD_BASE = 27,
  localparam int unsigned MOD_W   = $clog2(MOD_BASE + 5)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [ACC_W-1:0]      frac_word,
  output logic [CODE_W-1:0]     code,
  output logic [MOD_W-1:0]      modulus
);
  logic [MASH_STAGES-1:0][ACC_W-1:0] stage_in;
  logic [MASH_STAGES-1:0][ACC_W-1:0] acc_q;
  logic [MASH_STAGES-1:0][ACC_W-1:0] acc_nx;
  logic [MASH_STAGES-1:0]            carry;

  for (genvar i = 0; i < MASH_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stage_in[i] = frac_word;
    end else begin : g_tail
      assign stage_in[i] = acc_nx[i-1];
    end
    mash_accum #(.W(ACC_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .addend (stage_in[i]),
      .sum_q  (acc_q[i]),
      .sum_nx (acc_nx[i]),
      .carry  (carry[i])
    );
  end

  mash_combiner #(.MOD_BASE(MOD_BASE), .MOD_W(MOD_W)) u_comb (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .carry  (carry),
    .code_q (code),
    .mod_q  (modulus)
  );
endmodule

// File: rtl/mash_checker.sv
module mash_checker
  import mash_pkg::*;
#(
  parameter int unsigned ACC_W    = 16,
  parameter int unsigned MOD_BASE = 27,
  parameter int unsigned MOD_W    = 5
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              en,
  input logic [ACC_W-1:0]                  frac_word,
  input logic [CODE_W-1:0]                 code,
  input logic [MOD_W-1:0]                  modulus,
  input logic [MASH_STAGES-1:0][ACC_W-1:0] acc_state
);
  AST_RESET_VALUES: assert property (@(posedge clk) rst |=> (code == CODE_W'(CODE_OFS)) && (modulus == MOD_W'(MOD_BASE))); // R1
  AST_MOD_IN_RANGE: assert property (@(posedge clk) disable iff (rst) (int'(modulus) >= int'(MOD_BASE) + Y_MIN) && (int'(modulus) <= int'(MOD_BASE) + 4)); // R3
  AST_CODE_MOD_LINK: assert property (@(posedge clk) disable iff (rst) int'(modulus) == int'(MOD_BASE) + Y_MIN + int'(code)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(code) && $stable(modulus) && $stable(acc_state)); // R5
  AST_ZERO_WORD_QUIET: assert property (@(posedge clk) disable iff (rst) (en && frac_word == '0 && acc_state == '0) |=> acc_state == '0); // R6
endmodule

bind mash_modulus_ctrl mash_checker #(.ACC_W(ACC_W), .MOD_BASE(MOD_BASE), .MOD_W(MOD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .frac_word (frac_word),
  .code      (code),
  .modulus   (modulus),
  .acc_state (acc_q)
);

// File: tb/tb_mash_modulus_ctrl.sv
module tb_mash_modulus_ctrl;
  localparam int W    = 10;
  localparam int M    = 1 << W;
  localparam int BASE = 27;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] frac_word = '0;
  logic [2:0]   code;
  logic [4:0]   modulus;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  mash_modulus_ctrl #(.ACC_W(W), .MOD_BASE(BASE)) dut (
    .clk(clk), .rst(rst), .en(en), .frac_word(frac_word),
    .code(code), .modulus(modulus)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_k(input int k, input bit gap);
    longint s = 0;
    longint fl;
    longint err;
    bit rng_ok = 1, bnd_ok = 1, zero_ok = 1, seq_ok = 1;
    int bad_rng = 0, bad_err = 0, bad_zero = 3, bad_seq = 0, exp_seq = 0;
    int seq512[4] = '{3, 5, 2, 4};
    frac_word = k[W-1:0];
    do_reset();
    chk(code == 3 && modulus == 27, "R1 reset code", code, 3);
    for (int n = 1; n <= M; n++) begin
      en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      s += longint'(int'(modulus) - BASE);
      if (int'(modulus) < 24 || int'(modulus) > 31 || int'(modulus) != int'(code) + 24) begin
        if (rng_ok) bad_rng = int'(modulus);
        rng_ok = 0;
      end
      fl  = (longint'(n) * longint'(k)) >>> W;
      err = s - fl;
      if (err < -1 || err > 2) begin
        if (bnd_ok) bad_err = int'(err);
        bnd_ok = 0;
      end
      if (k == 0 && code != 3) begin
        zero_ok = 0; bad_zero = int'(code);
      end
      if (k == M / 2 && n <= 4 && int'(code) != seq512[n-1]) begin
        if (seq_ok) begin bad_seq = int'(code); exp_seq = seq512[n-1]; end
        seq_ok = 0;
      end
      if (k == M - 1 && n == 1) chk(code == 3, "R7 first code full-scale", code, 3);
      if (k == M - 1 && n == 2) chk(code == 6 && modulus == 30, "R7 second code full-scale", code, 6);
      if (gap && n == 100) begin
        logic [2:0] c0 = code;
        logic [4:0] m0 = modulus;
        bit hold_ok = 1;
        en = 1'b0;
        for (int g = 0; g < 5; g++) begin
          @(posedge clk);
          @(negedge clk);
          if (code != c0 || modulus != m0) hold_ok = 0;
        end
        chk(hold_ok, "R5 outputs held while idle", modulus, m0);
      end
    end
    en = 1'b0;
    chk(rng_ok, "R3 modulus window and code link", bad_rng, 27);
    chk(bnd_ok, "R4 running sum bound", bad_err, 0);
    chk(s >= k - 1 && s <= k + 2, "R4 window total", s, k);
    if (k == 0) chk(zero_ok && s == 0, "R6 zero word stays at code 3", bad_zero, 3);
    if (k == M / 2) chk(seq_ok, "R2 early sequence half-scale", bad_seq, exp_seq);
  endtask

  initial begin
    run_k(0, 1'b0);
    run_k(M / 2, 1'b0);
    run_k(M - 1, 1'b0);
    run_k(1, 1'b0);
    run_k(2, 1'b0);
    run_k(M / 2 + 1, 1'b0);
    run_k(M - 2, 1'b0);
    run_k(357, 1'b1);
    run_k(M / 4, 1'b1);
    for (int j = 1; j <= 24; j++) begin
      run_k((j * 331 + j * j * 7) % M, 1'b0);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule